// File: doc/BRIEF.md
# Half-Rate Serial Control Port Transmitter

This block sends fixed-length control words to a peripheral over a two-wire serial port: an active-low enable line (`en_n`) and a data line (`sdo`). The peripheral also receives a 13 MHz reference clock that never stops. While enable is high, the peripheral keeps an internal half-rate clock parked low. The first falling reference edge after enable goes low raises that hidden clock, and every later falling edge toggles it. The peripheral samples `sdo` on each rising edge of the hidden clock. The transmitter has to place every bit so that it is stable across one of those sampling points. It then has to release enable inside a half-period window so that the peripheral does not start a second transfer.

The block runs on an internal clock at twice the reference rate, so each internal edge lines up with one reference edge. The `rise_next` input tells the block which kind of reference edge the coming internal edge is: 1 for rising, 0 for falling. Words enter through a valid/ready handshake. `busy` reports that a transfer is on the wire.

In the text below, edge numbers count internal clock edges. The edge that drives `en_n` low is edge 0.

Top module: `hrsp_tx`

## Requirements
- R1: While `rst_n` is low and right after reset: `en_n`=1, `sdo`=0, `busy`=0, `load_ready`=1.
- R2: A word is taken on an edge where `load_valid` and `load_ready` are both 1. `load_ready` is 1 only in idle. It is 0 from the accepting edge until the cool-down ends, and always 0 while `busy` is 1.
- R3: `en_n` goes low only on an edge whose `rise_next` was 0 (a falling reference edge). This happens on the accepting edge if its `rise_next` was 0, and otherwise on the next edge.
- R4: Bits go out most significant first. `sdo` carries word bit 6 from edge 0. Bit 6−k is stable across edge 4k+2 (k=0..6), and edges 2, 6, …, 26 are the peripheral's seven sampling points.
- R5: During a transfer, `sdo` changes only on rising-reference edges (`rise_next`=1), namely edges 5, 9, …, 25.
- R6: `en_n` stays low for exactly 28 internal cycles and rises on edge 28. Edge 28 is a falling reference edge one reference period after the last sample. The peripheral therefore sees exactly seven sampling edges.
- R7: `busy` is 1 exactly while `en_n` is 0.
- R8: Between two transfers, `en_n` stays high for at least 4 internal cycles (two reference periods). With `load_valid` held high, the next transfer starts at edge 32.
- R9: `sdo` is 0 whenever `en_n` is 1.
- R10: `load_valid` while `load_ready` is 0 has no effect, and that word is never sent.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal clock at twice the reference rate |
| rst_n | input | 1 | Asynchronous active-low reset |
| rise_next | input | 1 | 1 when the coming clk edge is a rising reference edge |
| load_valid | input | 1 | Word offered for transmission |
| load_word | input | WORD_W | Word to send, MSB first |
| load_ready | output | 1 | Block can take a word |
| busy | output | 1 | Transfer in progress (enable asserted) |
| en_n | output | 1 | Active-low serial enable |
| sdo | output | 1 | Serial data |

## Verification
The bench builds the block with its default parameters: WORD_W=7, TAIL_REF=1 and GAP_REF=2. These are the only values at which its peripheral model and edge-numbered expectations apply. They bring the tight timing points within reach:
- release on the last falling edge before a spurious rising edge;
- the minimum two-period gap under back-to-back loading;
- both start paths, accepting on a falling edge and accepting on a rising edge.

Words with all-ones, all-zeros, alternating and single-bit patterns expose bit-order and shift-timing faults. A word offered during a transfer tests that it is ignored.

// File: rtl/hrsp_pkg.sv
package hrsp_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ARM  = 2'd1,
    ST_SEND = 2'd2,
    ST_COOL = 2'd3
  } hrsp_state_t;

  // Internal edge (enable-assert edge = 0) of the last peripheral sample.
  function automatic int last_sample_edge(input int word_w);
    return 4 * (word_w - 1) + 2;
  endfunction

  // Edge on which enable is released.
  function automatic int release_edge(input int word_w, input int tail_ref);
    return last_sample_edge(word_w) + 2 * tail_ref;
  endfunction

  // Earliest edge on which the next enable assertion may occur.
  function automatic int reopen_edge(input int word_w, input int tail_ref,
                                     input int gap_ref);
    return release_edge(word_w, tail_ref) + 2 * gap_ref;
  endfunction

  // True when the edge following slot value s must advance the data bit.
  function automatic logic is_shift_slot(input int s, input int word_w);
    return (s >= 4) && (s <= 4 * (word_w - 1)) && ((s % 4) == 0);
  endfunction

endpackage

// File: rtl/hrsp_sequencer.sv
module hrsp_sequencer #(
  parameter int WORD_W   = 7,
  parameter int TAIL_REF = 1,
  parameter int GAP_REF  = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic rise_next,
  input  logic load_valid,
  output logic load_ready,
  output logic load_fire,
  output logic start_ev,
  output logic shift_ev,
  output logic release_ev,
  output logic en_n,
  output logic busy
);
  import hrsp_pkg::*;

  localparam int REL_EDGE    = release_edge(WORD_W, TAIL_REF);
  localparam int REOPEN_EDGE = reopen_edge(WORD_W, TAIL_REF, GAP_REF);
  localparam int CNT_W       = $clog2(REOPEN_EDGE + 1);

  hrsp_state_t      state;
  logic [CNT_W-1:0] slot;
  logic             reopen_ev;

  assign load_ready = (state == ST_IDLE);
  assign load_fire  = load_valid && load_ready;
  assign start_ev   = !rise_next && (load_fire || (state == ST_ARM));
  assign shift_ev   = (state == ST_SEND) && is_shift_slot(int'(slot), WORD_W);
  assign release_ev = (state == ST_SEND) && (slot == CNT_W'(REL_EDGE - 1));
  assign reopen_ev  = (state == ST_COOL) && (slot == CNT_W'(REOPEN_EDGE - 2));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      slot  <= '0;
      en_n  <= 1'b1;
      busy  <= 1'b0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (load_fire) begin
            slot <= '0;
            if (start_ev) begin
              state <= ST_SEND;
              en_n  <= 1'b0;
              busy  <= 1'b1;
            end else begin
              state <= ST_ARM;
            end
          end
        end
        ST_ARM: begin
          if (start_ev) begin
            state <= ST_SEND;
            slot  <= '0;
            en_n  <= 1'b0;
            busy  <= 1'b1;
          end
        end
        ST_SEND: begin
          slot <= slot + CNT_W'(1);
          if (release_ev) begin
            state <= ST_COOL;
            en_n  <= 1'b1;
            busy  <= 1'b0;
          end
        end
        ST_COOL: begin
          slot <= slot + CNT_W'(1);
          if (reopen_ev) state <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/hrsp_shifter.sv
module hrsp_shifter #(
  parameter int WORD_W = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_fire,
  input  logic [WORD_W-1:0] load_word,
  input  logic              start_ev,
  input  logic              shift_ev,
  input  logic              release_ev,
  output logic              sdo
);
  logic [WORD_W-1:0] word_q;
  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] src;

  assign src = load_fire ? load_word : word_q;
  assign sdo = shreg[WORD_W-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q <= '0;
      shreg  <= '0;
    end else begin
      if (load_fire) word_q <= load_word;
      if (start_ev)        shreg <= src;
      else if (release_ev) shreg <= '0;
      else if (shift_ev)   shreg <= {shreg[WORD_W-2:0], 1'b0};
    end
  end

endmodule

// File: rtl/hrsp_tx.sv
module hrsp_tx #(
  parameter int WORD_W   = 7,
  parameter int TAIL_REF = 1,
  parameter int GAP_REF  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise_next,
  input  logic              load_valid,
  input  logic [WORD_W-1:0] load_word,
  output logic              load_ready,
  output logic              busy,
  output logic              en_n,
  output logic              sdo
);
  logic load_fire;
  logic start_ev;
  logic shift_ev;
  logic release_ev;

  hrsp_sequencer #(
    .WORD_W  (WORD_W),
    .TAIL_REF(TAIL_REF),
    .GAP_REF (GAP_REF)
  ) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .rise_next (rise_next),
    .load_valid(load_valid),
    .load_ready(load_ready),
    .load_fire (load_fire),
    .start_ev  (start_ev),
    .shift_ev  (shift_ev),
    .release_ev(release_ev),
    .en_n      (en_n),
    .busy      (busy)
  );

  hrsp_shifter #(
    .WORD_W(WORD_W)
  ) u_shf (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_fire (load_fire),
    .load_word (load_word),
    .start_ev  (start_ev),
    .shift_ev  (shift_ev),
    .release_ev(release_ev),
    .sdo       (sdo)
  );

endmodule

// File: rtl/hrsp_tx_chk.sv
module hrsp_tx_chk #(
  parameter int WORD_W   = 7,
  parameter int TAIL_REF = 1,
  parameter int GAP_REF  = 2
) (
  input logic clk,
  input logic rst_n,
  input logic rise_next,
  input logic load_ready,
  input logic busy,
  input logic en_n,
  input logic sdo,
  input logic start_ev,
  input logic shift_ev,
  input logic release_ev
);
  localparam int HOLD  = hrsp_pkg::release_edge(WORD_W, TAIL_REF);
  localparam int GAP_C = 2 * GAP_REF;
  localparam int CW    = $clog2(HOLD + GAP_C + 2) + 1;

  logic [CW-1:0] low_cnt;
  logic [CW-1:0] high_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      low_cnt  <= '0;
      high_cnt <= '1;
    end else begin
      if (en_n) begin
        low_cnt <= '0;
        if (high_cnt != '1) high_cnt <= high_cnt + CW'(1);
      end else begin
        high_cnt <= '0;
        if (low_cnt != '1) low_cnt <= low_cnt + CW'(1);
      end
    end
  end

  // R3
  start_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_n) |-> $past(!rise_next));
  // R3
  start_effect_chk: assert property (@(posedge clk) disable iff (!rst_n)
    start_ev |=> !en_n);
  // R6
  release_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_n) |-> $past(!rise_next));
  // R6
  release_ev_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    release_ev |-> !rise_next);
  // R6
  hold_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(en_n) |-> (low_cnt == CW'(HOLD)));
  // R8
  min_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(en_n) |-> (high_cnt >= CW'(GAP_C)));
  // R5
  sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_n && $past(!en_n) && !$stable(sdo)) |-> $past(rise_next));
  // R5
  shift_phase_chk: assert property (@(posedge clk) disable iff (!rst_n)
    shift_ev |-> rise_next);
  // R9
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    en_n |-> !sdo);
  // R7
  busy_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy == !en_n);
  // R2
  ready_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !load_ready);

endmodule

bind hrsp_tx hrsp_tx_chk #(
  .WORD_W  (WORD_W),
  .TAIL_REF(TAIL_REF),
  .GAP_REF (GAP_REF)
) u_hrsp_tx_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .rise_next (rise_next),
  .load_ready(load_ready),
  .busy      (busy),
  .en_n      (en_n),
  .sdo       (sdo),
  .start_ev  (start_ev),
  .shift_ev  (shift_ev),
  .release_ev(release_ev)
);

// File: tb/hrsp_tx_bench.sv
module hrsp_tx_bench;
  localparam int CLK_PERIOD = 38;
  localparam int WDOG       = 100000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rise_next = 1'b0;
  logic       load_valid = 1'b0;
  logic [6:0] load_word = '0;
  logic       load_ready, busy, en_n, sdo;

  int n_checks = 0;
  int n_err = 0;
  bit done = 0;
  bit started = 0;

  hrsp_tx u_hrsp_tx (
    .clk(clk), .rst_n(rst_n), .rise_next(rise_next),
    .load_valid(load_valid), .load_word(load_word),
    .load_ready(load_ready), .busy(busy), .en_n(en_n), .sdo(sdo)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) rise_next <= ~rise_next;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    n_checks++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Behavioural reference: phase 0 idle, 1 armed, 2 sending, 3 cool-down
  int         m_phase = 0;
  int         m_e = 0;
  logic [6:0] m_word = '0;
  logic [6:0] exp_q[$];
  int         pushed = 0;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_phase = 0;
      m_e = 0;
    end else begin
      case (m_phase)
        0: if (load_valid) begin
             m_word = load_word;
             exp_q.push_back(load_word);
             pushed++;
             if (!rise_next) begin m_phase = 2; m_e = 0; end
             else m_phase = 1;
           end
        1: if (!rise_next) begin m_phase = 2; m_e = 0; end
        2: begin m_e++; if (m_e == 28) m_phase = 3; end
        default: begin m_e++; if (m_e == 31) m_phase = 0; end
      endcase
    end
  end

  // Peripheral model and per-cycle comparison, evaluated between edges
  bit         p_en = 0;
  bit         p_c65 = 0;
  int         p_nb = 0;
  logic [6:0] p_bits = '0;
  int         got = 0;
  bit         prev_en = 1;
  logic       prev_sdo = 0;
  int         hi_run = 1000;

  always @(negedge clk) begin
    if (rst_n && started) begin
      int   j;
      logic e_sdo;
      j = (m_e == 0) ? 0 : (m_e - 1) / 4;
      if (j > 6) j = 6;
      e_sdo = (m_phase == 2) ? m_word[6 - j] : 1'b0;
      check(en_n == (m_phase != 2), "R6 en_n vs model", en_n, m_phase != 2);
      check(sdo == e_sdo, "R4 sdo vs model", sdo, e_sdo);
      check(busy == (m_phase == 2), "R7 busy vs model", busy, m_phase == 2);
      check(load_ready == (m_phase == 0), "R2 load_ready vs model", load_ready, m_phase == 0);
      if (en_n) check(sdo == 1'b0, "R9 sdo idle", sdo, 0);
      if (prev_en && !en_n) begin
        check(rise_next == 1'b1, "R3 enable fell on rising ref edge", 0, 1);
        check(hi_run >= 4, "R8 gap before transfer", hi_run, 4);
      end
      if (!prev_en && !en_n && (sdo != prev_sdo))
        check(rise_next == 1'b0, "R5 sdo changed on falling ref edge", 0, 1);
      if (en_n) hi_run++; else hi_run = 0;

      // coming edge handled by the peripheral model
      if (rise_next) begin
        if (!en_n) p_en = 1;
        else begin
          if (p_en) begin
            check(p_nb == 7, "R6 sampling edges per transfer", p_nb, 7);
            if (exp_q.size() > 0) begin
              logic [6:0] w;
              w = exp_q.pop_front();
              check(p_bits == w, "R4 received word", p_bits, w);
            end else check(0, "R10 unexpected word received", p_bits, 0);
            got++;
          end
          p_en = 0; p_c65 = 0; p_nb = 0; p_bits = '0;
        end
      end else if (p_en) begin
        p_c65 = !p_c65;
        if (p_c65) begin
          p_bits = {p_bits[5:0], sdo};
          p_nb++;
          if (p_nb > 7) check(0, "R6 extra sampling edge", p_nb, 7);
        end
      end
      prev_en = en_n;
      prev_sdo = sdo;
    end
  end

  task automatic send(input logic [6:0] w, input logic ph);
    while (!(load_ready && rise_next == ph)) @(negedge clk);
    load_word = w;
    load_valid = 1'b1;
    @(negedge clk);
    load_valid = 1'b0;
  endtask

  task automatic burst_one(input logic [6:0] w);
    load_word = w;
    load_valid = 1'b1;
    while (!load_ready) @(negedge clk);
    @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset values
    check(en_n == 1'b1, "R1 en_n in reset", en_n, 1);
    check(sdo == 1'b0, "R1 sdo in reset", sdo, 0);
    check(busy == 1'b0, "R1 busy in reset", busy, 0);
    check(load_ready == 1'b1, "R1 load_ready in reset", load_ready, 1);
    rst_n = 1'b1;
    started = 1;
    @(negedge clk);
    check(en_n == 1'b1 && load_ready == 1'b1, "R1 after reset", en_n, 1);

    send(7'h55, 1'b0);   // R3 accept on falling edge
    send(7'h2A, 1'b1);   // R3 accept on rising edge, armed path
    burst_one(7'h7F);    // R8 back-to-back loading
    burst_one(7'h00);
    burst_one(7'h41);
    load_valid = 1'b0;

    // R10 word offered while busy must be ignored
    send(7'h33, 1'b1);
    while (!busy) @(negedge clk);
    load_word = 7'h13;
    load_valid = 1'b1;
    repeat (10) @(negedge clk);
    load_valid = 1'b0;
    send(7'h6C, 1'b0);
    send(7'h01, 1'b1);
    send(7'h40, 1'b0);

    repeat (45) @(negedge clk);
    check(exp_q.size() == 0, "R10 all accepted words delivered", exp_q.size(), 0);
    check(got == 9, "R10 delivered word count", got, 9);
    check(pushed == 9, "R2 accepted word count", pushed, 9);
    finish_run();
  end

  initial begin
    repeat (WDOG) @(posedge clk);
    n_checks++;
    n_err++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", WDOG, 0);
    finish_run();
  end

endmodule